// File: doc/BRIEF.md
# Two-Way Byte Cache with Check-Bit Protected Lines

The block is a small data cache between a byte-wide requester and a word-wide backing memory. The address space is 16 bits. Each line holds one 32-bit word, and the cache has 128 sets of two ways. Alongside its tag and valid flag, every line stores six check bits computed from its data. On each lookup the cache compares tags and also recomputes the check bits. A line whose tag matches but whose data no longer agrees with its check bits is handled as a miss. The word is then fetched again from memory into that same way.

Writes go through to memory, and a write miss does not allocate a line. Memory therefore always holds a clean copy of every cached word, so reloading is always a correct recovery. An injection port flips one stored data bit. This lets a test stand in for a radiation upset.

The requester raises `req_i` while `busy_o` is low. The cache then answers with a one-cycle `resp_o` pulse, which carries `hit_o` and the read byte. Memory transactions hold `mem_req_o` until `mem_rdy_i` is seen at a clock edge.

Top module: `ecc_cache`

## Requirements
- R1: After reset every line is invalid, `busy_o`, `resp_o` and `mem_req_o` are low, and the first access to any address reports `hit_o`=0.
- R2: A read that hits raises `resp_o` for one cycle, at the second clock edge after the edge that accepts the request. It returns `hit_o`=1 and issues no memory request.
- R3: A read miss performs exactly one memory read of the whole word. It responds with `hit_o`=0 one edge after `mem_rdy_i` is sampled high, returning byte lane `addr[1:0]`, which is bits `8*addr[1:0]+7 : 8*addr[1:0]` of the word.
- R4: The address is split as byte offset `[1:0]`, set index `[8:2]` and tag `[15:9]`, and `mem_addr_o` carries `addr[15:2]`.
- R5: A read miss fills an invalid way if there is one, checking way 0 before way 1. Otherwise it fills the least recently used way. After any hit or fill, the set's replacement bit points at the other way.
- R6: Each line stores six Hamming check bits over its data. Any single flipped data bit makes a tag-matching line count as a miss. That line is refilled in its own way, so the other way of the set keeps its block.
- R7: Every write produces one memory write with `mem_be_o` one-hot at `addr[1:0]` and the byte replicated on all lanes. A write hit also updates the cached byte. A write miss allocates nothing. A write to a corrupted matching line drops that line.
- R8: `mem_req_o` and `mem_addr_o` stay stable until `mem_rdy_i` is sampled high. Each miss or write causes exactly one memory transaction.
- R9: While the cache is idle, `inj_i` inverts data bit `inj_bit_i` of way `inj_way_i` in set `inj_idx_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `busy_o` is low |
| we_i | input | 1 | 1 = byte write, 0 = byte read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Cache is serving an access |
| resp_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Access hit a clean valid line |
| rdata_o | output | 8 | Read byte, valid with `resp_o` |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory transaction is a write |
| mem_addr_o | output | 14 | Memory word address |
| mem_be_o | output | 4 | Byte strobes for writes |
| mem_wdata_o | output | 32 | Write word (byte replicated) |
| mem_rdy_i | input | 1 | Memory completes the transaction |
| mem_rdata_i | input | 32 | Read word, valid with `mem_rdy_i` |
| inj_i | input | 1 | Flip one stored data bit |
| inj_way_i | input | 1 | Way to corrupt |
| inj_idx_i | input | 7 | Set to corrupt |
| inj_bit_i | input | 5 | Data bit to flip |

## Verification
A wrong tag, valid flag or replacement bit shows up on `hit_o` within one access. It can also appear as an unexpected memory transaction, or a missing one. A bad victim choice only appears two accesses later, when a block that should have survived misses. The set sweep therefore revisits each set with three tags. Check bits that fail to cover a data position would let a corrupted byte through on `rdata_o` with `hit_o`=1 on the very next read. Injecting every one of the 32 data bits exposes that case at once.

// File: rtl/ecc_cache_pkg.sv
package ecc_cache_pkg;
  localparam int WORD_W = 32;
  localparam int CHK_W  = 6;
  localparam int NWAYS  = 2;  // replacement state is one bit per set

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_WR} cache_st_e;

  // Syndrome column of data bit pos: the pos-th code position that is not a power of two
  function automatic logic [CHK_W-1:0] chk_col(input int unsigned pos);
    int unsigned n;
    logic [CHK_W-1:0] r;
    n = 0;
    r = '0;
    for (int unsigned v = 3; v < (1 << CHK_W); v++) begin
      if ((v & (v - 1)) != 0) begin
        if (n == pos) r = CHK_W'(v);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_cache_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  always_comb begin
    chk_o = '0;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (data_i[i]) chk_o = chk_o ^ chk_col(i);
    end
  end
endmodule

// File: rtl/ecc_chk.sv
module ecc_chk
  import ecc_cache_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              err_o
);
  logic [CHK_W-1:0] calc;

  ecc_enc u_enc (.data_i(data_i), .chk_o(calc));

  assign err_o = |(calc ^ chk_i);
endmodule

// File: rtl/lru_tbl.sv
module lru_tbl #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             touch_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             evict_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;  // way to evict next

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (touch_i) lru_q[touch_idx_i] <= ~touch_way_i;
  end

  assign evict_o = lru_q[rd_idx_i];

  assert_lru_other_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> lru_q[$past(touch_idx_i)] != $past(touch_way_i));
endmodule

// File: rtl/ecc_cache.sv
module ecc_cache
  import ecc_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               wdata_i,
  output logic                     busy_o,
  output logic                     resp_o,
  output logic                     hit_o,
  output logic [7:0]               rdata_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-3:0]        mem_addr_o,
  output logic [WORD_W/8-1:0]      mem_be_o,
  output logic [WORD_W-1:0]        mem_wdata_o,
  input  logic                     mem_rdy_i,
  input  logic [WORD_W-1:0]        mem_rdata_i,
  input  logic                     inj_i,
  input  logic                     inj_way_i,
  input  logic [IDX_W-1:0]         inj_idx_i,
  input  logic [$clog2(WORD_W)-1:0] inj_bit_i
);
  localparam int OFFS_W = $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
  localparam int SETS   = 1 << IDX_W;

  cache_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, way_q, whit_q, resp_q, hit_q;
  logic [7:0]        wdata_q, rdata_q;

  logic [WORD_W-1:0] dat_q [NWAYS][SETS];
  logic [CHK_W-1:0]  chk_q [NWAYS][SETS];
  logic [TAG_W-1:0]  tag_q [NWAYS][SETS];
  logic [SETS-1:0]   val_q [NWAYS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFFS_W-1:0] offs;
  assign idx  = addr_q[OFFS_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign offs = addr_q[OFFS_W-1:0];

  logic [WORD_W-1:0] rd_dat [NWAYS];
  logic [NWAYS-1:0]  err_w, hit_w, bad_w;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic tag_eq;
    assign rd_dat[w] = dat_q[w][idx];
    ecc_chk u_chk (.data_i(rd_dat[w]), .chk_i(chk_q[w][idx]), .err_o(err_w[w]));
    assign tag_eq   = val_q[w][idx] && (tag_q[w][idx] == tag);
    assign hit_w[w] = tag_eq && !err_w[w];
    assign bad_w[w] = tag_eq && err_w[w];
  end

  logic any_hit, hit_way, victim, lru_evict;
  assign any_hit = |hit_w;
  assign hit_way = hit_w[1];

  always_comb begin
    if (|bad_w)               victim = bad_w[1];  // refill corrupted line in place
    else if (!val_q[0][idx])  victim = 1'b0;
    else if (!val_q[1][idx])  victim = 1'b1;
    else                      victim = lru_evict;
  end

  logic [WORD_W-1:0] hit_word, merged, wr_line;
  logic [CHK_W-1:0]  wr_chk;
  assign hit_word = rd_dat[hit_way];

  always_comb begin
    merged = hit_word;
    merged[{offs, 3'b000} +: 8] = wdata_q;
  end

  assign wr_line = (st_q == S_FILL) ? mem_rdata_i : merged;
  ecc_enc u_enc (.data_i(wr_line), .chk_o(wr_chk));

  logic line_we, line_way, inj_go, touch, touch_way;
  assign line_we  = (st_q == S_FILL && mem_rdy_i) || (st_q == S_LOOK && we_q && any_hit);
  assign line_way = (st_q == S_FILL) ? way_q : hit_way;
  assign inj_go   = inj_i && (st_q == S_IDLE);
  assign touch     = (st_q == S_LOOK && any_hit) || (st_q == S_FILL && mem_rdy_i);
  assign touch_way = (st_q == S_FILL) ? way_q : hit_way;

  lru_tbl #(.IDX_W(IDX_W)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch),
    .touch_idx_i(idx),
    .touch_way_i(touch_way),
    .rd_idx_i   (idx),
    .evict_o    (lru_evict)
  );

  always_ff @(posedge clk_i) begin
    if (line_we) begin
      dat_q[line_way][idx] <= wr_line;
      chk_q[line_way][idx] <= wr_chk;
      tag_q[line_way][idx] <= tag;
    end else if (inj_go) begin
      dat_q[inj_way_i][inj_idx_i][inj_bit_i] <= ~dat_q[inj_way_i][inj_idx_i][inj_bit_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWAYS; w++) val_q[w] <= '0;
    end else begin
      for (int w = 0; w < NWAYS; w++) begin
        if (st_q == S_FILL && mem_rdy_i && way_q == w[0]) val_q[w][idx] <= 1'b1;
        else if (st_q == S_LOOK && we_q && bad_w[w])      val_q[w][idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      way_q   <= 1'b0;
      whit_q  <= 1'b0;
      resp_q  <= 1'b0;
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          st_q    <= S_LOOK;
        end
        S_LOOK: begin
          if (we_q) begin
            whit_q <= any_hit;
            st_q   <= S_WR;
          end else if (any_hit) begin
            resp_q  <= 1'b1;
            hit_q   <= 1'b1;
            rdata_q <= hit_word[{offs, 3'b000} +: 8];
            st_q    <= S_IDLE;
          end else begin
            way_q <= victim;
            st_q  <= S_FILL;
          end
        end
        S_FILL: if (mem_rdy_i) begin
          resp_q  <= 1'b1;
          hit_q   <= 1'b0;
          rdata_q <= mem_rdata_i[{offs, 3'b000} +: 8];
          st_q    <= S_IDLE;
        end
        S_WR: if (mem_rdy_i) begin
          resp_q  <= 1'b1;
          hit_q   <= whit_q;
          rdata_q <= wdata_q;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign resp_o      = resp_q;
  assign hit_o       = hit_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (st_q == S_FILL) || (st_q == S_WR);
  assign mem_we_o    = (st_q == S_WR);
  assign mem_addr_o  = addr_q[ADDR_W-1:OFFS_W];
  assign mem_be_o    = (st_q == S_WR) ? ((WORD_W/8)'(1) << offs) : '1;
  assign mem_wdata_o = {(WORD_W/8){wdata_q}};

  assert_resp_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |=> !resp_o);

  assert_hit_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOOK && !we_q && any_hit) |=> !mem_req_o);

  assert_one_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOOK) |-> $onehot0(hit_w));

  assert_fill_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FILL && mem_rdy_i) |=> hit_w[way_q]);

  assert_no_alloc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOOK && we_q && !any_hit) |=> !(|hit_w));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: tb/test_ecc_cache.sv
module test_ecc_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        busy_o, resp_o, hit_o;
  logic [7:0]  rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [13:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic        mem_rdy_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        inj_i = 1'b0, inj_way_i = 1'b0;
  logic [6:0]  inj_idx_i = '0;
  logic [4:0]  inj_bit_i = '0;

  always #10 clk_i = ~clk_i;

  ecc_cache i_ecc_cache (.*);

  int total = 0, bad = 0, mem_txn = 0;
  bit done = 0;
  logic [15:0] cur_a = '0;
  logic [7:0] wr_mem [int];
  bit m_val [2][128];
  int m_tag [2][128];
  int m_lru [128];
  bit m_bad [2][128];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (wr_mem.exists(int'(a))) return wr_mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] mk(input int tg, input int idx, input int off);
    return {7'(tg), 7'(idx), 2'(off)};
  endfunction

  function automatic int way_of(input int idx, input int tg);
    for (int w = 0; w < 2; w++) if (m_val[w][idx] && m_tag[w][idx] == tg) return w;
    return -1;
  endfunction

  // memory model: answers one negedge after a request appears
  always @(negedge clk_i) begin
    if (mem_rdy_i) mem_rdy_i = 1'b0;
    else if (mem_req_o) begin
      mem_txn++;
      chk(mem_addr_o == cur_a[15:2], "R4 word address", mem_addr_o, cur_a[15:2]);
      if (mem_we_o) begin
        chk(mem_be_o == 4'(1 << cur_a[1:0]), "R7 byte strobe", mem_be_o, 4'(1 << cur_a[1:0]));
        for (int k = 0; k < 4; k++)
          if (mem_be_o[k]) wr_mem[int'({mem_addr_o, 2'(k)})] = mem_wdata_o[8*k +: 8];
      end else begin
        for (int k = 0; k < 4; k++) mem_rdata_i[8*k +: 8] = mem_byte({mem_addr_o, 2'(k)});
      end
      mem_rdy_i = 1'b1;
    end
  end

  task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] wd, input string lbl);
    int idx, tg, hw, bw, v, n, exp_txn;
    logic [7:0] exp_d;
    idx = int'(a[8:2]);
    tg  = int'(a[15:9]);
    hw = -1;
    bw = -1;
    for (int w = 0; w < 2; w++)
      if (m_val[w][idx] && m_tag[w][idx] == tg) begin
        if (m_bad[w][idx]) bw = w; else hw = w;
      end
    exp_d = mem_byte(a);
    exp_txn = (we || hw < 0) ? 1 : 0;
    cur_a = a;
    mem_txn = 0;
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    n = 0;
    while (!resp_o && n < 50) begin
      @(negedge clk_i);
      n++;
    end
    chk(resp_o, {lbl, " R8 response arrives"}, resp_o, 1);
    chk(hit_o == (hw >= 0), {lbl, " hit flag"}, hit_o, hw >= 0);
    if (!we) chk(rdata_o == exp_d, {lbl, " R3 R4 read byte"}, rdata_o, exp_d);
    chk(mem_txn == exp_txn, {lbl, " R8 transaction count"}, mem_txn, exp_txn);
    if (we) begin
      if (bw >= 0) m_val[bw][idx] = 1'b0;
      if (hw >= 0) m_lru[idx] = 1 - hw;
    end else if (hw >= 0) begin
      m_lru[idx] = 1 - hw;
    end else begin
      if (bw >= 0) v = bw;
      else if (!m_val[0][idx]) v = 0;
      else if (!m_val[1][idx]) v = 1;
      else v = m_lru[idx];
      m_val[v][idx] = 1'b1;
      m_tag[v][idx] = tg;
      m_bad[v][idx] = 1'b0;
      m_lru[idx] = 1 - v;
    end
  endtask

  task automatic inject(input int w, input int idx, input int b);
    inj_i = 1'b1; inj_way_i = w[0]; inj_idx_i = 7'(idx); inj_bit_i = 5'(b);
    @(negedge clk_i);
    inj_i = 1'b0;
    if (m_val[w][idx]) m_bad[w][idx] = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R1 busy after reset", busy_o, 0);
    chk(!resp_o, "R1 resp after reset", resp_o, 0);
    chk(!mem_req_o, "R1 mem_req after reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep all sets with three tags
    for (int i = 0; i < 128; i++) begin
      acc(0, mk(1, i, i % 4), 0, "R1 cold miss");
      acc(0, mk(1, i, (i + 1) % 4), 0, "R2 same word");
      acc(0, mk(2, i, i % 4), 0, "R5 free way");
      acc(0, mk(1, i, i % 4), 0, "R2 hit again");
      acc(0, mk(3, i, i % 4), 0, "R5 evict lru");
      acc(0, mk(2, i, (i + 2) % 4), 0, "R5 evict lru again");
    end

    // every data bit corrupted once, on each of the two ways
    for (int b = 0; b < 32; b++) begin
      inject(way_of(b, 2), b, b);
      acc(0, mk(2, b, b % 4), 0, "R6 R9 corrupt miss");
      acc(0, mk(3, b, 0), 0, "R6 other way kept");
      acc(0, mk(2, b, 3), 0, "R6 refilled");
      inject(way_of(64 + b, 3), 64 + b, b);
      acc(0, mk(3, 64 + b, 1), 0, "R6 R9 corrupt miss");
      acc(0, mk(2, 64 + b, 2), 0, "R6 other way kept");
      acc(0, mk(3, 64 + b, 1), 0, "R6 refilled");
    end

    // write-through behaviour
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'(i * 7) ^ 8'hA5;
      acc(1, mk(2, i, i % 4), d, "R7 write hit");
      acc(0, mk(2, i, i % 4), 0, "R7 updated byte");
      acc(1, mk(5, i, i % 4), ~d, "R7 write miss");
      acc(0, mk(5, i, i % 4), 0, "R7 no allocate");
      acc(0, mk(5, i, (i + 1) % 4), 0, "R7 other lanes kept");
    end

    // write to a corrupted matching line
    for (int i = 100; i < 104; i++) begin
      inject(way_of(i, 3), i, i % 32);
      acc(1, mk(3, i, 0), 8'h3C, "R7 corrupt write");
      acc(0, mk(3, i, 0), 0, "R7 corrupt line dropped");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule